// File: doc/BRIEF.md
# Memory Bit-Field Access Unit

This block reads, tests and rewrites an arbitrary bit field held in byte-addressed memory whose bits are numbered big-endian. A request names a base byte address, a signed 32-bit bit offset from that base, a 5-bit width code, a 32-bit insert value and an operation. The unit locates the bytes the field spans, from one to five of them. It reads those bytes one at a time over a synchronous single-port memory interface and evaluates the field. For the modifying operations it writes the same bytes back, with only the field bits altered.

The operations are:

- unsigned extract and signed extract;
- insert of a value;
- invert, clear and set of every field bit;
- a search for the first one bit, counted from the field's most significant end.

The result word and the N and Z flag sources are registered. They appear together with a one-cycle `done` pulse. The unit handles one request at a time. While `busy` is high, new requests are ignored.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The width code gives the field length in bits. Code 0 means 32 bits, and any other code n means n bits.
- R2: The first byte touched is base + floor(offset/8), taken modulo 2^ADDR_W. The starting bit inside that byte is offset mod 8, in the range 0..7. A negative offset therefore borrows from the byte below.
- R3: Exactly floor((bitpos + length - 1)/8) + 1 bytes are read, which is between 1 and 5. Bit position 0 is the most significant bit of the first byte, and positions increase toward less significant bits and then toward higher addresses.
- R4: Op code 0 (unsigned extract) returns the field zero-extended. Op code 1 (signed extract) returns it sign-extended to 32 bits.
- R5: Op code 2 (insert) replaces the field with the low `length` bits of the insert value. Its result is the old field left-justified to bit 31, and its N source is bit `length-1` of the insert value.
- R6: Op code 3 inverts every field bit, op code 4 clears every field bit and op code 5 sets every field bit. Each returns the old field left-justified to bit 31.
- R7: Op code 6 (find first one) returns offset + the number of leading zeros of the field. When the field is all zero, it returns offset + length.
- R8: Bits outside the field are left unchanged in memory. Op codes 0, 1, 6 and 7 issue no write, and op code 7 returns the same value as op code 0.
- R9: The Z source is 1 exactly when the field was all zero before the request. For every op other than insert, the N source is the old field's most significant bit.
- R10: An accepted request raises `busy` from the next cycle until `done`. `done` is a single-cycle pulse, and `busy` is low while it is high. Requests presented while `busy` is high have no effect.
- R11: After reset, `busy`, `done`, `mem_en`, `mem_we`, `result`, `flag_n` and `flag_z` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 3 | Operation code (0 to 7, see R4 to R8) |
| req_base | input | ADDR_W | Base byte address |
| req_offset | input | 32 | Signed bit offset from the base |
| req_width | input | 5 | Width code, where 0 means 32 bits |
| req_value | input | 32 | Insert value (low bits used) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Registered result word |
| flag_n | output | 1 | Negative flag source |
| flag_z | output | 1 | Zero flag source |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after a read |

## Verification
Reads are pipelined, so in one cycle the unit captures the byte returned for read k-1 while it issues the address for read k. A fault in the capture index would therefore place a byte in the wrong lane of the field window. This overlap is provoked by fields that span two to five bytes. The widest case uses width code 0 at bit position 5, and negative offsets move the span across the base address. The check compares every extracted value, every returned flag and the full memory image after each operation against a bit-by-bit model in the bench.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_BYTES = 5;
  localparam int WIN_W     = MAX_BYTES * 8;
  localparam int LEN_W     = $clog2(WORD_W + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6,
    OP_RSVD = 3'd7
  } bfu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_CALC  = 3'd3,
    ST_WRITE = 3'd4
  } bfu_state_e;

  function automatic logic bfu_writes(input logic [2:0] op);
    return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
  endfunction
endpackage

// File: rtl/bfu_locate.sv
module bfu_locate
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [31:0]       offset,
  input  logic [4:0]        wcode,
  output logic [ADDR_W-1:0] start_addr,
  output logic [2:0]        bitpos,
  output logic [LEN_W-1:0]  len,
  output logic [IDX_W-1:0]  last_idx
);
  logic signed [31:0] byte_off;
  logic [LEN_W-1:0]   span;

  always_comb begin
    byte_off   = $signed(offset) >>> 3;
    start_addr = base + byte_off[ADDR_W-1:0];
    bitpos     = offset[2:0];
    len        = (wcode == 5'd0) ? LEN_W'(WORD_W) : LEN_W'(wcode);
    span       = LEN_W'(bitpos) + len - LEN_W'(1);
    last_idx   = IDX_W'(span >> 3);
  end
endmodule

// File: rtl/bfu_lzc.sv
module bfu_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge
  import bfu_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  input  logic [2:0]        bitpos,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        op,
  input  logic [31:0]       offset,
  input  logic [WORD_W-1:0] value,
  output logic [WIN_W-1:0]  new_window,
  output logic [WORD_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z
);
  logic [WORD_W-1:0] top, mask, old_left, old_right, old_sext, ins_left, new_left;
  logic [LEN_W-1:0]  rsh, lead;
  logic [WIN_W-1:0]  mask_w, new_w;

  bfu_lzc #(.W(WORD_W), .CW(LEN_W)) u_lzc (.vec(old_left), .cnt(lead));

  always_comb begin
    top       = WORD_W'((window << bitpos) >> (WIN_W - WORD_W));
    mask      = ~({WORD_W{1'b1}} >> len);
    old_left  = top & mask;
    rsh       = LEN_W'(WORD_W) - len;
    old_right = old_left >> rsh;
    old_sext  = WORD_W'($signed(old_left) >>> rsh);
    ins_left  = value << rsh;

    case (bfu_op_e'(op))
      OP_INS:  new_left = ins_left;
      OP_CHG:  new_left = ~old_left & mask;
      OP_CLR:  new_left = '0;
      OP_SET:  new_left = mask;
      default: new_left = old_left;
    endcase

    mask_w     = {mask, {(WIN_W - WORD_W){1'b0}}} >> bitpos;
    new_w      = {new_left, {(WIN_W - WORD_W){1'b0}}} >> bitpos;
    new_window = (window & ~mask_w) | (new_w & mask_w);

    case (bfu_op_e'(op))
      OP_EXTS: result = old_sext;
      OP_INS, OP_CHG, OP_CLR, OP_SET: result = old_left;
      OP_FFO:  result = offset + 32'((old_left == '0) ? len : lead);
      default: result = old_right;
    endcase

    flag_z = (old_left == '0);
    flag_n = (bfu_op_e'(op) == OP_INS) ? ins_left[WORD_W-1] : old_left[WORD_W-1];
  end
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_offset,
  input  logic [4:0]        req_width,
  input  logic [31:0]       req_value,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  bfu_state_e        state_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       off_q, val_q;
  logic [4:0]        wcode_q;
  logic [IDX_W-1:0]  idx_q, cap_idx_q;
  logic              cap_vld_q;
  logic [WIN_W-1:0]  win_q;
  logic [31:0]       result_q;
  logic              n_q, z_q, done_q;

  logic [ADDR_W-1:0] start_addr;
  logic [2:0]        bitpos;
  logic [LEN_W-1:0]  len;
  logic [IDX_W-1:0]  last_idx;
  logic [WIN_W-1:0]  m_window;
  logic [31:0]       m_result;
  logic              m_n, m_z;
  logic [7:0]        wbyte;

  bfu_locate #(.ADDR_W(ADDR_W)) u_locate (
    .base(base_q), .offset(off_q), .wcode(wcode_q),
    .start_addr(start_addr), .bitpos(bitpos), .len(len), .last_idx(last_idx)
  );

  bfu_merge u_merge (
    .window(win_q), .bitpos(bitpos), .len(len), .op(op_q), .offset(off_q),
    .value(val_q), .new_window(m_window), .result(m_result),
    .flag_n(m_n), .flag_z(m_z)
  );

  always_comb begin
    wbyte = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (idx_q == IDX_W'(b)) wbyte = win_q[WIN_W-1-8*b -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      base_q    <= '0;
      off_q     <= '0;
      val_q     <= '0;
      wcode_q   <= '0;
      idx_q     <= '0;
      cap_idx_q <= '0;
      cap_vld_q <= 1'b0;
      win_q     <= '0;
      result_q  <= '0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cap_vld_q <= 1'b0;
      if (cap_vld_q) begin
        for (int b = 0; b < MAX_BYTES; b++) begin
          if (cap_idx_q == IDX_W'(b)) win_q[WIN_W-1-8*b -: 8] <= mem_rdata;
        end
      end
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= req_op;
            base_q  <= req_base;
            off_q   <= req_offset;
            wcode_q <= req_width;
            val_q   <= req_value;
            idx_q   <= '0;
            win_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          cap_vld_q <= 1'b1;
          cap_idx_q <= idx_q;
          if (idx_q == last_idx) begin
            idx_q   <= '0;
            state_q <= ST_DRAIN;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_DRAIN: state_q <= ST_CALC;
        ST_CALC: begin
          result_q <= m_result;
          n_q      <= m_n;
          z_q      <= m_z;
          if (bfu_writes(op_q)) begin
            win_q   <= m_window;
            idx_q   <= '0;
            state_q <= ST_WRITE;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (idx_q == last_idx) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign result    = result_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign mem_en    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = start_addr + ADDR_W'(idx_q);
  assign mem_wdata = wbyte;
endmodule

// File: rtl/bfu_chk.sv
module bfu_chk
  import bfu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       busy,
  input logic       done,
  input logic       mem_en,
  input logic       mem_we
);
  logic [2:0] op_t;
  logic [3:0] rd_cnt, wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_t   <= '0;
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (req_valid && !busy) begin
      op_t   <= req_op;
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      if (mem_en && !mem_we) rd_cnt <= rd_cnt + 4'd1;
      if (mem_en && mem_we)  wr_cnt <= wr_cnt + 4'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && !busy) |=> busy); // R10
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_en); // R8
  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (busy && mem_we) |-> bfu_writes(op_t)); // R8
  AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (rst) done |-> (rd_cnt >= 4'd1 && rd_cnt <= 4'(MAX_BYTES))); // R3
  AST_WRITE_MATCH: assert property (@(posedge clk) disable iff (rst) (done && bfu_writes(op_t)) |-> (wr_cnt == rd_cnt)); // R8
endmodule

bind bitfield_mem_unit bfu_chk u_bfu_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/bitfield_mem_unit_bench.sv
module bitfield_mem_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int MEM_N = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_base = '0;
  logic [31:0] req_offset = '0, req_width_v = '0, req_value = '0;
  logic [4:0] req_width = '0;
  logic busy, done, flag_n, flag_z, mem_en, mem_we;
  logic [31:0] result;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] ram [MEM_N];
  logic [7:0] ref_mem [MEM_N];
  int checks = 0, failures = 0, cycles = 0;
  logic exp_write = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_mem_unit #(.ADDR_W(AW)) u_bitfield_mem_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_width(req_width),
    .req_value(req_value), .busy(busy), .done(done), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  // per-clock comparison: a write is only legal for modifying ops
  always @(negedge clk) begin
    if (!rst && mem_en && mem_we) begin
      checks++;
      if (!exp_write) begin
        failures++;
        $display("FAIL R8 unexpected write actual=we1 expected=we0 addr=%0d", mem_addr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // bit-serial behavioural model over ref_mem
  task automatic model(input logic [2:0] op, input int base, input logic [31:0] off,
                       input logic [4:0] wc, input logic [31:0] val,
                       output logic [31:0] res, output logic n, output logic z);
    int len = (wc == 0) ? 32 : int'(wc);
    logic [31:0] fu = 0;
    logic [63:0] t;
    int first = -1;
    logic f0 = 1'b0;
    for (int i = 0; i < len; i++) begin
      longint a = longint'($signed(off)) + i;
      int bi = (base + int'(a >>> 3)) & (MEM_N - 1);
      int sh = 7 - int'(a & 7);
      logic b = ref_mem[bi][sh];
      if (i == 0) f0 = b;
      if (b && first < 0) first = i;
      fu = (fu << 1) | 32'(b);
      case (op)
        3'd2: ref_mem[bi][sh] = val[len-1-i];
        3'd3: ref_mem[bi][sh] = ~b;
        3'd4: ref_mem[bi][sh] = 1'b0;
        3'd5: ref_mem[bi][sh] = 1'b1;
        default: ;
      endcase
    end
    t = {32'b0, fu} << (32 - len);
    z = (fu == 0);
    n = (op == 3'd2) ? val[len-1] : f0;
    case (op)
      3'd1: res = (f0 && len < 32) ? (fu | (32'hFFFF_FFFF << len)) : fu;
      3'd2, 3'd3, 3'd4, 3'd5: res = t[31:0];
      3'd6: res = off + 32'((first < 0) ? len : first);
      default: res = fu;
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input int base, input logic [31:0] off,
                        input logic [4:0] wc, input logic [31:0] val, input string tag,
                        input bit poke_busy = 0);
    logic [31:0] er; logic en, ez; int mism = 0;
    model(op, base, off, wc, val, er, en, ez);
    @(negedge clk);
    exp_write = (op >= 3'd2 && op <= 3'd5);
    req_valid = 1'b1; req_op = op; req_base = AW'(base); req_offset = off;
    req_width = wc; req_value = val;
    @(negedge clk);
    if (poke_busy) begin
      // R10: a request while busy must be ignored
      req_op = 3'd5; req_offset = off + 32'd3; req_width = 5'd0; req_value = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    check({tag, " result"}, result, er);
    check("R9 flag_n", 32'(flag_n), 32'(en));
    check("R9 flag_z", 32'(flag_z), 32'(ez));
    check("R10 busy low at done", 32'(busy), 32'd0);
    for (int a = 0; a < MEM_N; a++) if (ram[a] !== ref_mem[a]) mism++;
    check("R8 memory image mismatches", 32'(mism), 32'd0);
    @(negedge clk);
    check("R10 done single pulse", 32'(done), 32'd0);
    exp_write = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < MEM_N; a++) begin
      ram[a] = 8'($urandom);
      ref_mem[a] = ram[a];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 busy", 32'(busy), 0);
    check("R11 done", 32'(done), 0);
    check("R11 mem_en/we", {30'b0, mem_en, mem_we}, 0);
    check("R11 result/flags", result | 32'(flag_n) | 32'(flag_z), 0);

    ram[100] = 8'hA5; ram[101] = 8'h3C; ref_mem[100] = 8'hA5; ref_mem[101] = 8'h3C;
    run_op(3'd0, 100, 32'd4, 5'd8, 0, "R4 extu two bytes");      // 0x53
    run_op(3'd1, 100, 32'd0, 5'd4, 0, "R4 exts negative");
    run_op(3'd0, 300, 32'd5, 5'd0, 0, "R1 R3 width32 five bytes");
    run_op(3'd1, 300, 32'd7, 5'd2, 0, "R3 two-bit straddle");
    run_op(3'd0, 200, -32'sd3, 5'd6, 0, "R2 negative offset");
    run_op(3'd1, 200, -32'sd17, 5'd11, 0, "R2 negative offset far");
    run_op(3'd2, 400, 32'd13, 5'd12, 32'h0000_0ABC, "R5 insert");
    run_op(3'd2, 400, -32'sd6, 5'd0, 32'h8765_4321, "R5 insert width32");
    run_op(3'd3, 410, 32'd3, 5'd20, 0, "R6 change");
    run_op(3'd4, 420, 32'd9, 5'd15, 0, "R6 clear");
    run_op(3'd5, 430, -32'sd1, 5'd9, 0, "R6 set");
    ram[500] = 8'h00; ram[501] = 8'h04; ref_mem[500] = 8'h00; ref_mem[501] = 8'h04;
    run_op(3'd6, 500, 32'd2, 5'd12, 0, "R7 ffo found");
    ram[510] = 8'h00; ram[511] = 8'h00; ref_mem[510] = 8'h00; ref_mem[511] = 8'h00;
    run_op(3'd6, 510, 32'd3, 5'd10, 0, "R7 ffo zero field");
    run_op(3'd7, 100, 32'd4, 5'd8, 0, "R8 reserved op");
    run_op(3'd0, 600, 32'd6, 5'd17, 0, "R10 ignored while busy", 1);

    for (int k = 0; k < 300; k++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      int base = $urandom_range(100, 900);
      logic [31:0] off = 32'($signed($urandom_range(0, 127)) - 64);
      run_op(op, base, off, 5'($urandom), $urandom, tag_of(op));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule